// File: doc/BRIEF.md
# Thresholded Event Performance Counter

This block is a single performance-monitor counter with an event filter in front of it. In every cycle it receives a 7-bit event increment together with two unit-wide enables, one for counting and one for overflow signalling. A 32-bit control word sets how the event is shaped before it is counted. The event can pass through unchanged and be added in full. It can instead be reduced to a single bit by comparing it with a threshold, optionally inverted. That bit can then be restricted to its rising edges.

The accumulator is 48 bits wide and always wraps. A one-cycle overflow pulse leaves the block when both the local and the unit-wide overflow enables allow it. A small register port writes and reads the control word and the two halves of the count. Reads are combinational from a separate read address.

Top module: `perf_event_counter`

## Requirements
- R1: After reset the control word reads 0, both count halves read 0 and `ovf_pulse` is 0.
- R2: The control word holds the threshold in bits 31:24, invert in bit 23, local count enable in bit 22, local overflow enable in bit 20 and edge mode in bit 18. All other bits, including 21 and 19, read as 0 whatever is written. Register addresses are 0 for control, 1 for count bits 31:0, 2 for count bits 47:32 (read zero-extended) and 3, which reads 0 and ignores writes.
- R3: With a zero threshold the whole event value is added each counting cycle, and the invert and edge bits have no effect.
- R4: With a nonzero threshold and invert clear, the count rises by exactly 1 in a counting cycle when threshold >= event (event zero-extended to 8 bits), and by 0 otherwise.
- R5: With a nonzero threshold and invert set, the count rises by exactly 1 when threshold < event.
- R6: With a nonzero threshold and edge mode set, only a 0-to-1 change of the compare bit adds 1. The previous compare bit resets to 0 and is tracked in every cycle, including cycles in which counting is disabled.
- R7: The count changes through increments only in cycles where both the local count enable and `unit_cnt_en` are 1.
- R8: The 48-bit count wraps modulo 2^48, including when a multi-bit increment crosses the wrap point.
- R9: `ovf_pulse` is 1 for exactly the cycle after an increment that carries out of bit 47, and only if the local overflow enable and `unit_ovf_en` were both 1 in the cycle of that increment.
- R10: A write to either count half in a cycle replaces that half, and no increment is applied in that cycle. The new value is readable on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_inc | input | 7 | Event increment value for this cycle |
| unit_cnt_en | input | 1 | Unit-wide count enable |
| unit_ovf_en | input | 1 | Unit-wide overflow enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| ovf_pulse | output | 1 | One-cycle overflow indication |

## Verification
The assertions check several properties on every cycle. Reserved control bits stay zero. A compare-mode increment never exceeds one. An edge-mode increment implies the previous compare bit was low. The count holds when it is idle. A count write wins over an increment. Every overflow pulse follows a carry that both enables allowed. Whether the amount added is the right one for a given threshold, invert and edge setting can only be shown by the bench's scenarios, which compare the count against an independent model. The same holds for wrap-around crossings, for edge tracking across disabled stretches and for the read-back layout.

// File: rtl/perfctr_pkg.sv
package perfctr_pkg;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned THR_W    = 8;
  localparam int unsigned THR_LSB  = 24;
  localparam int unsigned INV_BIT  = 23;
  localparam int unsigned CEN_BIT  = 22;
  localparam int unsigned OVFE_BIT = 20;
  localparam int unsigned EDGE_BIT = 18;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 32'hFFD4_0000;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_CNT_LO = 2'd1,
    RA_CNT_HI = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

  // Threshold test on an 8-bit widened event value.
  function automatic logic thr_hit(input logic [THR_W-1:0] thr,
                                   input logic inv,
                                   input logic [THR_W-1:0] evt8);
    logic le;
    le = (evt8 <= thr);
    return inv ? ~le : le;
  endfunction

  // Keep only writable control bits.
  function automatic logic [CTRL_W-1:0] ctrl_sanitize(input logic [CTRL_W-1:0] d);
    return d & CTRL_MASK;
  endfunction
endpackage

// File: rtl/pc_ctrl_reg.sv
module pc_ctrl_reg
  import perfctr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_sanitize(wr_data);
  end
endmodule

// File: rtl/pc_event_filter.sv
module pc_event_filter
  import perfctr_pkg::*;
#(
  parameter int unsigned EVT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_inc,
  input  logic [THR_W-1:0] thr,
  input  logic             inv,
  input  logic             edge_mode,
  output logic             thr_on,
  output logic             hit,
  output logic             prev_q,
  output logic [EVT_W-1:0] inc_amt
);
  localparam int unsigned PAD_W = THR_W - EVT_W;

  logic [THR_W-1:0] evt8;
  logic             rise;
  logic             bit_out;

  assign evt8    = {{PAD_W{1'b0}}, evt_inc};
  assign thr_on  = |thr;
  assign hit     = thr_hit(thr, inv, evt8);
  assign rise    = hit & ~prev_q;
  assign bit_out = edge_mode ? rise : hit;

  always_comb begin
    if (thr_on) inc_amt = {{(EVT_W-1){1'b0}}, bit_out};
    else        inc_amt = evt_inc;
  end

  // Tracks the compare bit every cycle, counting or not.
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= hit;
  end
endmodule

// File: rtl/pc_accum.sv
module pc_accum
  import perfctr_pkg::*;
#(
  parameter int unsigned EVT_W = 7,
  parameter int unsigned CNT_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_go,
  input  logic              ovf_allow,
  input  logic [EVT_W-1:0]  inc_amt,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              add_wrap,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_q
);
  localparam int unsigned HI_W  = CNT_W - CTRL_W;
  localparam int unsigned EXT_W = CNT_W + 1 - EVT_W;

  logic [CNT_W:0] sum_w;
  logic           take_add;

  assign sum_w    = {1'b0, cnt_q} + {{EXT_W{1'b0}}, inc_amt};
  assign take_add = cnt_go & ~wr_lo & ~wr_hi;
  assign add_wrap = take_add & sum_w[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (wr_lo) begin
        cnt_q[CTRL_W-1:0] <= wr_data;
      end else if (wr_hi) begin
        cnt_q[CNT_W-1:CTRL_W] <= wr_data[HI_W-1:0];
      end else if (cnt_go) begin
        cnt_q <= sum_w[CNT_W-1:0];
        ovf_q <= sum_w[CNT_W] & ovf_allow;
      end
    end
  end
endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import perfctr_pkg::*;
#(
  parameter int unsigned EVT_W = 7,
  parameter int unsigned CNT_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_inc,
  input  logic              unit_cnt_en,
  input  logic              unit_ovf_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [CTRL_W-1:0] rd_data,
  output logic              ovf_pulse
);
  localparam int unsigned HI_W = CNT_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ctrl, wr_lo, wr_hi;
  logic              thr_on, hit, prev_q;
  logic [EVT_W-1:0]  inc_amt;
  logic              cnt_go, ovf_allow, add_wrap;
  logic [CNT_W-1:0]  cnt_q;

  assign wr_ctrl = wr_en && (wr_addr == RA_CTRL);
  assign wr_lo   = wr_en && (wr_addr == RA_CNT_LO);
  assign wr_hi   = wr_en && (wr_addr == RA_CNT_HI);

  pc_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q)
  );

  pc_event_filter #(.EVT_W(EVT_W)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_inc   (evt_inc),
    .thr       (ctrl_q[THR_LSB +: THR_W]),
    .inv       (ctrl_q[INV_BIT]),
    .edge_mode (ctrl_q[EDGE_BIT]),
    .thr_on    (thr_on),
    .hit       (hit),
    .prev_q    (prev_q),
    .inc_amt   (inc_amt)
  );

  assign cnt_go    = ctrl_q[CEN_BIT] & unit_cnt_en;
  assign ovf_allow = ctrl_q[OVFE_BIT] & unit_ovf_en;

  pc_accum #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_go    (cnt_go),
    .ovf_allow (ovf_allow),
    .inc_amt   (inc_amt),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .add_wrap  (add_wrap),
    .cnt_q     (cnt_q),
    .ovf_q     (ovf_pulse)
  );

  always_comb begin
    unique case (rd_addr)
      RA_CTRL:   rd_data = ctrl_q;
      RA_CNT_LO: rd_data = cnt_q[CTRL_W-1:0];
      RA_CNT_HI: rd_data = {{(2*CTRL_W-CNT_W){1'b0}}, cnt_q[CNT_W-1:CTRL_W]};
      default:   rd_data = '0;
    endcase
  end

  logic unused_hi_w;
  assign unused_hi_w = (HI_W == 0) & hit;
endmodule

// File: rtl/pc_checker.sv
module pc_checker
  import perfctr_pkg::*;
#(
  parameter int unsigned EVT_W = 7,
  parameter int unsigned CNT_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [EVT_W-1:0]  evt_inc,
  input logic              thr_on,
  input logic              prev_q,
  input logic [EVT_W-1:0]  inc_amt,
  input logic              cnt_go,
  input logic              ovf_allow,
  input logic              add_wrap,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic [CTRL_W-1:0] wr_data,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              ovf_pulse
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[21] == 1'b0) && (ctrl_q[19] == 1'b0));

  a_r3_raw_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_on |-> (inc_amt == evt_inc));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    thr_on |-> (inc_amt <= 1));

  a_r6_edge_prev_low: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_on && ctrl_q[EDGE_BIT] && (inc_amt != 0)) |-> !prev_q);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_go && !wr_lo && !wr_hi) |=> $stable(cnt_q));

  a_r9_ovf_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(ovf_allow));

  a_r8_ovf_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(add_wrap));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_q[CTRL_W-1:0] == $past(wr_data)));
endmodule

bind perf_event_counter pc_checker #(.EVT_W(EVT_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_q    (ctrl_q),
  .evt_inc   (evt_inc),
  .thr_on    (thr_on),
  .prev_q    (prev_q),
  .inc_amt   (inc_amt),
  .cnt_go    (cnt_go),
  .ovf_allow (ovf_allow),
  .add_wrap  (add_wrap),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .wr_data   (wr_data),
  .cnt_q     (cnt_q),
  .ovf_pulse (ovf_pulse)
);

// File: tb/perf_event_counter_tb_top.sv
module perf_event_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_inc = '0;
  logic        unit_cnt_en = 1'b0, unit_ovf_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ovf_pulse;

  int n_chk = 0, n_bad = 0, n_cyc = 0;
  bit done = 0;

  // model state
  bit [31:0] m_ctrl = '0;
  bit [47:0] m_cnt = '0;
  bit        m_prev = 0, m_ovf = 0;

  always #10 clk = ~clk;

  perf_event_counter dut_i (
    .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .unit_cnt_en(unit_cnt_en),
    .unit_ovf_en(unit_ovf_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ovf_pulse(ovf_pulse)
  );

  function automatic bit m_hit(bit [7:0] thr, bit inv, bit [6:0] e);
    bit above;
    above = ({1'b0, e} > thr);
    return inv ? above : !above;
  endfunction

  function automatic string tag_of(bit [31:0] c);
    if (c[31:24] == 0) return "R3";
    if (c[18]) return "R6";
    if (c[23]) return "R5";
    return "R4";
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    rd_addr = 2'd1; #1 cmp(tag, "count_lo", rd_data, m_cnt[31:0]);
    rd_addr = 2'd2; #1 cmp(tag, "count_hi", rd_data, {16'h0, m_cnt[47:32]});
    rd_addr = 2'd0; #1 cmp(tag, "ctrl", rd_data, m_ctrl);
    rd_addr = 2'd3; #1 cmp(tag, "addr3", rd_data, 32'h0);
    cmp(tag, "ovf_pulse", {31'h0, ovf_pulse}, {31'h0, m_ovf});
  endtask

  task automatic model_step();
    bit [7:0] thr; bit go, hit; bit [6:0] amt; bit [48:0] tmp;
    thr = m_ctrl[31:24];
    go  = m_ctrl[22] & unit_cnt_en;
    hit = m_hit(thr, m_ctrl[23], evt_inc);
    if (thr == 0) amt = evt_inc;
    else if (m_ctrl[18]) amt = {6'h0, hit & !m_prev};
    else amt = {6'h0, hit};
    m_prev = hit;
    m_ovf  = 0;
    if (wr_en && wr_addr == 2'd1) m_cnt[31:0] = wr_data;
    else if (wr_en && wr_addr == 2'd2) m_cnt[47:32] = wr_data[15:0];
    else if (go) begin
      tmp   = {1'b0, m_cnt} + {42'h0, amt};
      m_cnt = tmp[47:0];
      m_ovf = tmp[48] & m_ctrl[20] & unit_ovf_en;
    end
    if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data & 32'hFFD4_0000;
  endtask

  // one clock: drive, advance, update model, check after the edge
  task automatic cyc(string tag, bit [6:0] e, bit uc, bit uo,
                     bit w = 0, bit [1:0] wa = 0, bit [31:0] wd = 0);
    evt_inc = e; unit_cnt_en = uc; unit_ovf_en = uo;
    wr_en = w; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 0;
    check_all(tag);
  endtask

  task automatic wctl(string tag, bit [31:0] v);
    cyc(tag, 7'd0, 0, 0, 1, 2'd0, v);
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", n_cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R2: writable bits and reserved bits
    wctl("R2", 32'hFFFF_FFFF);
    wctl("R2", 32'h002B_FFFF);

    // R3: zero threshold, raw add; invert/edge ignored
    wctl("R3", 32'h0040_0000);
    cyc("R3", 7'd5, 1, 0); cyc("R3", 7'd127, 1, 0); cyc("R3", 7'd0, 1, 0);
    wctl("R3", 32'h00C4_0000);
    cyc("R3", 7'd9, 1, 0); cyc("R3", 7'd9, 1, 0); cyc("R3", 7'd3, 1, 0);

    // R4: threshold 3
    wctl("R4", 32'h0340_0000);
    for (int i = 0; i < 8; i++) cyc("R4", 7'(i), 1, 0);
    wctl("R4", 32'h8040_0000);
    cyc("R4", 7'd127, 1, 0); cyc("R4", 7'd0, 1, 0);

    // R5: inverted threshold 3
    wctl("R5", 32'h03C0_0000);
    for (int i = 0; i < 8; i++) cyc("R5", 7'(i), 1, 0);

    // R6: edges of threshold-1 inverted compare (event>1)
    wctl("R6", 32'h01C4_0000);
    cyc("R6", 7'd2, 1, 0); cyc("R6", 7'd2, 1, 0); cyc("R6", 7'd0, 1, 0);
    cyc("R6", 7'd5, 1, 0); cyc("R6", 7'd5, 0, 0); cyc("R6", 7'd5, 1, 0);
    cyc("R6", 7'd0, 0, 0); cyc("R6", 7'd6, 1, 0);

    // R7: either enable low blocks counting
    wctl("R7", 32'h0040_0000);
    cyc("R7", 7'd7, 0, 0); cyc("R7", 7'd7, 1, 0);
    wctl("R7", 32'h0000_0000);
    cyc("R7", 7'd7, 1, 0);

    // R8/R9: wrap with multi-bit increment
    wctl("R9", 32'h0050_0000);
    cyc("R8", 0, 0, 0, 1, 2'd2, 32'h0000_FFFF);
    cyc("R8", 0, 0, 0, 1, 2'd1, 32'hFFFF_FFFE);
    cyc("R8", 7'd5, 1, 1); cyc("R9", 7'd0, 1, 1);
    cyc("R8", 0, 0, 0, 1, 2'd2, 32'h0000_FFFF);
    cyc("R8", 0, 0, 0, 1, 2'd1, 32'hFFFF_FFFF);
    cyc("R9", 7'd1, 1, 0); cyc("R9", 7'd0, 1, 1);
    wctl("R9", 32'h0040_0000);
    cyc("R8", 0, 0, 0, 1, 2'd1, 32'hFFFF_FFFF);
    cyc("R9", 7'd0, 0, 0, 1, 2'd2, 32'h0000_FFFF);
    cyc("R9", 7'd2, 1, 1);

    // R10: write beats increment
    cyc("R10", 7'd9, 1, 1, 1, 2'd1, 32'h1234_5678);
    cyc("R10", 7'd9, 1, 1, 1, 2'd2, 32'h0000_ABCD);
    cyc("R10", 7'd9, 1, 1, 1, 2'd3, 32'hFFFF_FFFF);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit [31:0] r; bit [6:0] e;
      r = $urandom;
      e = (r[3:0] < 4) ? 7'($urandom_range(0, 3)) : 7'($urandom);
      if (r[9:4] == 0) begin
        bit [31:0] c; c = $urandom;
        c[31:24] = (r[10]) ? 8'($urandom_range(0, 6)) : c[31:24];
        c[22] = r[11] | r[12];
        wctl(tag_of(c), c);
      end else if (r[9:4] == 1) begin
        cyc("R10", e, r[13], r[14], 1, 2'd2, 32'h0000_FFFF);
        cyc("R8", e, r[13], r[14], 1, 2'd1, 32'hFFFF_FFFF - 32'($urandom_range(0, 40)));
      end else begin
        cyc(tag_of(m_ctrl), e, (r[15:14] != 0), r[16]);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule